// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor port and a slower, word-wide main-memory port. It keeps four lines of two 32-bit words each. Each line is selected by low-order address bits and identified by a tag made of the address bits above them. A single comparator checks the tag of the indexed line against the incoming address to decide between hit and miss.

Reads that hit are answered from the line without touching memory. Reads that miss fetch both words of the line, lowest word first, and then return the requested word. Every write goes through to memory. A write that misses claims the indexed line: it stores the new word, fetches the sibling word from memory so the line is complete, marks the line valid and then issues the memory write. The processor accepts one request at a time and sees `cpu_ready` low until that request has finished.

Top module: `dmc_cache`

## Requirements
- R1: Address bit [2] selects the word within a line, bits [4:3] select one of the four lines, and bits [31:5] form the tag. Addresses whose tags differ do not hit each other's data.
- R2: After reset `cpu_ready` is 1, `mem_req` and `cpu_done` are 0, and every line is invalid, so the first access to any line misses.
- R3: A read hit raises `cpu_done` with `cpu_hit`=1 and the stored word in the cycle after acceptance, and makes no memory access.
- R4: A read miss issues exactly two memory reads, the word at the line base (bit 2 = 0) first and then the one at bit 2 = 1. It answers with `cpu_hit`=0 and the requested word. Afterwards both words of that line hit.
- R5: A write hit updates the cached word and issues exactly one memory write of that address and data, with no memory read. It answers with `cpu_hit`=1 after the memory acknowledge.
- R6: A write miss issues exactly one memory read, for the sibling word of the line, then one memory write of the new word. It answers with `cpu_hit`=0. Afterwards the line is valid and holds the new word merged with the fetched sibling.
- R7: Two addresses with equal bits [4:3] and different tags evict each other. For example, reading 1008, then 1040, then 1008 misses all three times.
- R8: While a memory request is outstanding, `cpu_ready` is 0. A memory request keeps its address, direction and write data unchanged until it is acknowledged.
- R9: `cpu_done` is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Lookup result of the completed request |
| cpu_rdata | output | 32 | Read data, valid with cpu_done on a read |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request direction, 1 = write |
| mem_addr | output | 32 | Memory word byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
On a write miss two data writes meet in one line: the processor's new word is stored at acceptance, and the refill word from memory lands later. If the refill is not steered away from the written word, it overwrites that word. The sweep writes to both word positions of lines whose current tag differs, then reads both words back. The read of the written word must return the new data, and the read of the sibling must return the memory value; the count of memory reads must be one. A second collision comes from requests issued on the very cycle a completion appears. This is checked by matching the count of completion cycles against the number of requests.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) tag_q[g] <= wr_tag;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R4/R6: a freshly written line answers a lookup of its own tag
  p_alloc_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!((lk_idx == $past(wr_idx)) && (lk_tag == $past(wr_tag))) || lk_hit));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 2,
  parameter int DW     = 32,
  parameter int IDX_W  = 2,
  parameter int WSEL_W = 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_sel,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] word_q [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_l
    for (genvar w = 0; w < WORDS; w++) begin : g_w
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == IDX_W'(l)) && (wr_sel == WSEL_W'(w)))
          word_q[l][w] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_idx][rd_sel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW     = 32,
  parameter int WORDS  = 2,
  parameter int OFF_W  = 2,
  parameter int WSEL_W = 1,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DW-1:0]     cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  output logic              tw_en,
  output logic [IDX_W-1:0]  tw_idx,
  output logic [TAG_W-1:0]  tw_tag,
  output logic              dw_en,
  output logic [IDX_W-1:0]  dw_idx,
  output logic [WSEL_W-1:0] dw_sel,
  output logic [DW-1:0]     dw_data,
  output logic [IDX_W-1:0]  dr_idx,
  output logic [WSEL_W-1:0] dr_sel,
  input  logic [DW-1:0]     dr_data
);
  localparam logic [WSEL_W-1:0] LAST_SEL = WSEL_W'(WORDS - 1);
  localparam logic [OFF_W-1:0]  OFF_ZERO = '0;

  dmc_state_e        state_q, state_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0]  a_tag_q, a_tag_d;
  logic [IDX_W-1:0]  a_idx_q, a_idx_d;
  logic [WSEL_W-1:0] a_sel_q, a_sel_d;
  logic              we_q, we_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic              lhit_q, lhit_d;
  logic              done_q, done_d;
  logic              rhit_q, rhit_d;
  logic [DW-1:0]     rdata_q, rdata_d;

  logic [TAG_W-1:0]  c_tag;
  logic [IDX_W-1:0]  c_idx;
  logic [WSEL_W-1:0] c_sel;
  logic              idle, in_fill, accept, skip, last, step;

  assign c_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx   = cpu_addr[OFF_W+WSEL_W +: IDX_W];
  assign c_sel   = cpu_addr[OFF_W +: WSEL_W];

  assign idle    = (state_q == ST_IDLE);
  assign in_fill = (state_q == ST_FILL);
  assign accept  = cpu_req && idle;
  assign skip    = we_q && (cnt_q == a_sel_q);
  assign last    = (cnt_q == LAST_SEL);
  assign step    = in_fill && (skip || mem_ack);

  // processor side
  assign cpu_ready = idle;
  assign cpu_done  = done_q;
  assign cpu_hit   = rhit_q;
  assign cpu_rdata = rdata_q;

  // memory side
  assign mem_req   = (in_fill && !skip) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = mem_we ? {a_tag_q, a_idx_q, a_sel_q, OFF_ZERO}
                            : {a_tag_q, a_idx_q, cnt_q, OFF_ZERO};
  assign mem_wdata = wdata_q;

  // arrays
  assign lk_idx  = c_idx;
  assign lk_tag  = c_tag;
  assign tw_en   = step && last;
  assign tw_idx  = a_idx_q;
  assign tw_tag  = a_tag_q;
  assign dw_en   = (accept && cpu_we) || (in_fill && !skip && mem_ack);
  assign dw_idx  = idle ? c_idx : a_idx_q;
  assign dw_sel  = idle ? c_sel : cnt_q;
  assign dw_data = idle ? cpu_wdata : mem_rdata;
  assign dr_idx  = idle ? c_idx : a_idx_q;
  assign dr_sel  = idle ? c_sel : a_sel_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    a_tag_d = a_tag_q;
    a_idx_d = a_idx_q;
    a_sel_d = a_sel_q;
    we_d    = we_q;
    wdata_d = wdata_q;
    lhit_d  = lhit_q;
    done_d  = 1'b0;
    rhit_d  = rhit_q;
    rdata_d = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          a_tag_d = c_tag;
          a_idx_d = c_idx;
          a_sel_d = c_sel;
          we_d    = cpu_we;
          wdata_d = cpu_wdata;
          lhit_d  = lk_hit;
          cnt_d   = '0;
          if (!cpu_we && lk_hit) begin
            done_d  = 1'b1;
            rhit_d  = 1'b1;
            rdata_d = dr_data;
          end else if (lk_hit) begin
            state_d = ST_WRITE;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (step) begin
          cnt_d = cnt_q + 1'b1;
          if (last) begin
            if (we_q) begin
              state_d = ST_WRITE;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              rhit_d  = 1'b0;
              rdata_d = (cnt_q == a_sel_q) ? mem_rdata : dr_data;
            end
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          rhit_d  = lhit_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      a_tag_q <= '0;
      a_idx_q <= '0;
      a_sel_q <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      lhit_q  <= 1'b0;
      done_q  <= 1'b0;
      rhit_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      a_tag_q <= a_tag_d;
      a_idx_q <= a_idx_d;
      a_sel_q <= a_sel_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      lhit_q  <= lhit_d;
      done_q  <= done_d;
      rhit_q  <= rhit_d;
      rdata_q <= rdata_d;
    end
  end

  // R1: processor addresses are word aligned
  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[OFF_W-1:0] == OFF_ZERO));

  // R8: a pending memory request does not change until acknowledged
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R8: no new processor request while memory is busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R3: read hit completes next cycle with no memory traffic
  p_read_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && !cpu_we && lk_hit) |=> (cpu_done && cpu_hit && !mem_req));

  // R5: the memory write acknowledge ends the transaction
  p_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (cpu_done && cpu_ready));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx, tw_idx, dw_idx, dr_idx;
  logic [TAG_W-1:0]  lk_tag, tw_tag;
  logic              lk_hit, tw_en, dw_en;
  logic [WSEL_W-1:0] dw_sel, dr_sel;
  logic [DATA_W-1:0] dw_data, dr_data;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .DW(DATA_W), .WORDS(LINE_WORDS), .OFF_W(OFF_W),
    .WSEL_W(WSEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_tag(tw_tag),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_sel(dw_sel), .dw_data(dw_data),
    .dr_idx(dr_idx), .dr_sel(dr_sel), .dr_data(dr_data)
  );

  dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_tag(tw_tag)
  );

  dmc_data_store #(
    .LINES(LINES), .WORDS(LINE_WORDS), .DW(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_data (
    .clk(clk),
    .wr_en(dw_en), .wr_idx(dw_idx), .wr_sel(dw_sel), .wr_data(dw_data),
    .rd_idx(dr_idx), .rd_sel(dr_sel), .rd_data(dr_data)
  );
endmodule

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready, cpu_done, cpu_hit;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  dmc_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, n_txn = 0;
  bit finished = 1'b0;

  // memory model with varying latency
  logic [31:0] mem [512];
  int n_rd, n_wr, n_done, wcnt, lat_q;
  logic [31:0] rd_h0, rd_h1, wr_last, wr_last_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 32'hA500_0000 ^ (i * 32'h0001_0203);
      mem_ack <= 1'b0; mem_rdata <= '0; wcnt <= 0; lat_q <= 0;
      n_rd <= 0; n_wr <= 0; n_done <= 0;
      rd_h0 <= '0; rd_h1 <= '0; wr_last <= '0; wr_last_d <= '0;
    end else begin
      if (cpu_done) n_done <= n_done + 1;
      if (mem_ack) begin
        mem_ack <= 1'b0; wcnt <= 0;
      end else if (mem_req) begin
        if (wcnt >= lat_q) begin
          mem_ack <= 1'b1;
          lat_q   <= (lat_q == 2) ? 0 : lat_q + 1;
          if (mem_we) begin
            mem[mem_addr[10:2]] <= mem_wdata;
            n_wr <= n_wr + 1; wr_last <= mem_addr; wr_last_d <= mem_wdata;
          end else begin
            mem_rdata <= mem[mem_addr[10:2]];
            n_rd <= n_rd + 1; rd_h0 <= rd_h1; rd_h1 <= mem_addr;
          end
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  // reference line state
  logic        ref_vld [4];
  logic [26:0] ref_tag [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    logic [1:0]  idx;
    logic [26:0] tg;
    logic [31:0] base, exp_d;
    bit exp_hit;
    int rd0, wr0, lat;
    idx = addr[4:3]; tg = addr[31:5];
    base = {addr[31:3], 3'b000};
    exp_hit = ref_vld[idx] && (ref_tag[idx] == tg);
    while (!cpu_ready) @(negedge clk);
    exp_d = mem[addr[10:2]];
    rd0 = n_rd; wr0 = n_wr;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    n_txn++;
    if (!(exp_hit && !we))
      chk(!cpu_ready && !cpu_done, "R8 busy after accept", {31'd0, cpu_ready}, 32'd0);
    lat = 0;
    while (!cpu_done && lat < 200) begin @(negedge clk); lat++; end
    chk(cpu_done, "R9 completion seen", {31'd0, cpu_done}, 32'd1);
    chk(cpu_hit == exp_hit, "R1/R7 hit flag", {31'd0, cpu_hit}, {31'd0, exp_hit});
    if (!we) chk(cpu_rdata == exp_d, "R4 read data", cpu_rdata, exp_d);
    if (!we && exp_hit) begin
      chk(lat == 0, "R3 hit latency", lat, 0);
      chk(n_rd == rd0 && n_wr == wr0, "R3 no memory access", n_rd - rd0 + n_wr - wr0, 0);
    end else if (!we) begin
      chk(n_rd - rd0 == 2 && n_wr == wr0, "R4 two reads", n_rd - rd0, 2);
      chk(rd_h0 == base && rd_h1 == base + 4, "R4 refill order", rd_h0, base);
    end else if (exp_hit) begin
      chk(n_rd == rd0 && n_wr - wr0 == 1, "R5 one write", n_wr - wr0, 1);
      chk(wr_last == addr && wr_last_d == wd, "R5 write addr/data", wr_last, addr);
    end else begin
      chk(n_rd - rd0 == 1 && n_wr - wr0 == 1, "R6 one read one write", n_rd - rd0, 1);
      chk(rd_h1 == (addr ^ 32'h4), "R6 sibling fetched", rd_h1, addr ^ 32'h4);
      chk(wr_last == addr && wr_last_d == wd, "R6 write addr/data", wr_last_d, wd);
    end
    ref_vld[idx] = 1'b1; ref_tag[idx] = tg;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 4; i++) begin ref_vld[i] = 1'b0; ref_tag[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(cpu_ready, "R2 ready after reset", {31'd0, cpu_ready}, 32'd1);
    chk(!mem_req, "R2 no memory request", {31'd0, mem_req}, 32'd0);
    chk(!cpu_done, "R2 no completion", {31'd0, cpu_done}, 32'd0);

    // R1/R4/R7: read sweep over three tags, every line and word
    for (int t = 0; t < 3; t++)
      for (int l = 0; l < 4; l++)
        for (int w = 0; w < 2; w++)
          acc(1'b0, 32'(t * 32 + l * 8 + w * 4), '0);

    // R5/R6: write sweep, hits and misses on both word positions
    for (int t = 1; t < 4; t++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++)
          acc(1'b1, 32'(t * 96 + l * 8 + w * 4), 32'hC0DE_0000 | 32'(t * 256 + l * 8 + w * 4));

    // R6: merged line readback after write misses
    for (int l = 0; l < 4; l++) begin
      acc(1'b1, 32'(640 + l * 8 + 4), 32'h5EED_0000 | 32'(l));
      acc(1'b0, 32'(640 + l * 8 + 4), '0);
      acc(1'b0, 32'(640 + l * 8), '0);
    end

    // R7: the 1008 / 1040 collision on line 2
    acc(1'b0, 32'd1008, '0);
    acc(1'b0, 32'd1040, '0);
    acc(1'b0, 32'd1008, '0);
    acc(1'b0, 32'd1012, '0);

    repeat (3) @(negedge clk);
    // R9: one completion cycle per request
    chk(n_done == n_txn, "R9 completion count", n_done, n_txn);
    chk(cpu_ready && !mem_req, "R8 idle at end", {31'd0, cpu_ready}, 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule